// File: doc/BRIEF.md
# Colored Region Access Monitor

This block sits beside the memory port of one hardware thread and vets every load and store before it is allowed to proceed. Software fills a small table of address ranges, each carrying a color number. The block looks up each access address in that table. If the address is colored, it compares the color with the thread's set of currently held colors. A colored access whose color is not held is stopped. A user-level entry trap is then raised with the color number, so that a handler can open the critical section for that color.

Software keeps the held-color set itself, through an add command and a remove command. The add command places a color in the lowest free slot and reports that slot's index at once. The index is the bit position that acquire and release bitmaps elsewhere in the thread use for the same slot. The remove command frees a slot by index. A trap stays raised, and the access stays stalled, until software acknowledges it. The stalled access is then looked up again. It proceeds if its color was added in the meantime, and traps again if it was not.

Top module: `colored_access_monitor`

## Requirements
- R1: After reset no trap is raised, every range entry is empty so every access proceeds, and the held-color set is empty (add_slot = 0, add_full = 0).
- R2: An access whose address lies in no valid range entry is accepted (acc_ready = 1) in the same cycle that acc_valid is high, and raises no trap.
- R3: An access whose address lies in a valid entry's inclusive range [base, limit] and whose color is in no valid slot is not accepted. trap_valid rises on the next clock edge, with trap_color equal to that entry's color.
- R4: When several valid entries cover the address, only the entry with the lowest index decides the access's color.
- R5: An access whose color is held in any valid slot, from 0 to 7, proceeds without a trap.
- R6: While trap_valid is high, acc_ready is low and trap_color is stable until trap_ack is seen on a clock edge. trap_valid is low from the following cycle, and the still-presented access is then looked up again against the current held set.
- R7: add_slot shows the lowest-index free slot and add_full is high when all 8 slots are valid. An add with add_en high writes add_color into that slot. An add while full changes nothing.
- R8: A remove with rm_en high clears the valid bit of slot rm_slot, so accesses of that color trap again.
- R9: Loads (acc_store = 0) and stores (acc_store = 1) are checked identically.
- R10: A table write with tbl_wr_valid = 0 empties the entry, and its range no longer matches any access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A load or store is presented; it is held until accepted |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Access address |
| acc_ready | output | 1 | Access is accepted this cycle |
| trap_valid | output | 1 | Entry trap pending |
| trap_color | output | COLOR_W | Color of the pending trap |
| trap_ack | input | 1 | Software acknowledges the pending trap |
| tbl_wr_en | input | 1 | Write one range entry |
| tbl_wr_idx | input | clog2(RANGE_N) | Entry index to write |
| tbl_wr_valid | input | 1 | Valid bit of the entry being written |
| tbl_wr_base | input | ADDR_W | Inclusive lower bound |
| tbl_wr_limit | input | ADDR_W | Inclusive upper bound |
| tbl_wr_color | input | COLOR_W | Color of the range |
| add_en | input | 1 | Add a held color |
| add_color | input | COLOR_W | Color to add |
| add_slot | output | clog2(OWN_N) | Lowest free slot, where the next add lands |
| add_full | output | 1 | No free slot |
| rm_en | input | 1 | Remove a held color |
| rm_slot | input | clog2(OWN_N) | Slot to free |

## Verification
The bench aims at addresses exactly on a range's base and limit. A design with an exclusive bound would let those accesses through. It covers overlapping ranges whose lowest entry is held while a higher entry is not. A design that resolved the wrong way would trap there, or would report the wrong color. The bench holds a trap for several cycles to catch a trap that drops or changes color without an acknowledge. It adds a color during a pending trap, which exposes a design that forgets to look the access up again after the acknowledge. It also fills all eight slots, frees one in the middle, and checks that add_full, the reuse of the lowest free slot and the renewed trapping are right.

// File: rtl/cam_pkg.sv
package cam_pkg;
   typedef enum logic {
      HOLD_IDLE = 1'b0,
      HOLD_TRAP = 1'b1
   } hold_state_e;
endpackage

// File: rtl/cam_range_table.sv
module cam_range_table #(
   parameter int ADDR_W  = 32,
   parameter int COLOR_W = 6,
   parameter int N       = 8,
   localparam int IDX_W  = $clog2(N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_valid,
   input  logic [ADDR_W-1:0]  wr_base,
   input  logic [ADDR_W-1:0]  wr_limit,
   input  logic [COLOR_W-1:0] wr_color,
   input  logic [ADDR_W-1:0]  lk_addr,
   output logic               lk_hit,
   output logic [COLOR_W-1:0] lk_color
);
   logic [N-1:0]       ent_v;
   logic [ADDR_W-1:0]  ent_base  [N];
   logic [ADDR_W-1:0]  ent_limit [N];
   logic [COLOR_W-1:0] ent_color [N];
   logic [N-1:0]       hit_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_v <= '0;
         for (int i = 0; i < N; i++) begin
            ent_base[i]  <= '0;
            ent_limit[i] <= '0;
            ent_color[i] <= '0;
         end
      end else if (wr_en) begin
         ent_v[wr_idx]     <= wr_valid;
         ent_base[wr_idx]  <= wr_base;
         ent_limit[wr_idx] <= wr_limit;
         ent_color[wr_idx] <= wr_color;
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = ent_v[g] && (lk_addr >= ent_base[g]) && (lk_addr <= ent_limit[g]);
   end

   // lowest index wins: scan downward so the last assignment is the lowest hit
   always_comb begin
      lk_color = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_vec[i]) lk_color = ent_color[i];
      end
   end
   assign lk_hit = |hit_vec;

   // R10: an invalidated entry stops matching from the next cycle on
   a_r10_inval_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_valid) |=> !hit_vec[$past(wr_idx)]);
endmodule

// File: rtl/cam_owned_set.sv
module cam_owned_set #(
   parameter int COLOR_W = 6,
   parameter int N       = 8,
   localparam int IDX_W  = $clog2(N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               add_en,
   input  logic [COLOR_W-1:0] add_color,
   input  logic               rm_en,
   input  logic [IDX_W-1:0]   rm_idx,
   input  logic [COLOR_W-1:0] chk_color,
   output logic               chk_owned,
   output logic [IDX_W-1:0]   free_idx,
   output logic               full
);
   logic [N-1:0]       slot_v;
   logic [COLOR_W-1:0] slot_c [N];
   logic [N-1:0]       match_vec;

   for (genvar g = 0; g < N; g++) begin : g_match
      assign match_vec[g] = slot_v[g] && (slot_c[g] == chk_color);
   end
   assign chk_owned = |match_vec;
   assign full      = &slot_v;

   always_comb begin
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!slot_v[i]) free_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_v <= '0;
         for (int i = 0; i < N; i++) slot_c[i] <= '0;
      end else begin
         if (rm_en) slot_v[rm_idx] <= 1'b0;
         if (add_en && !full) begin
            slot_v[free_idx] <= 1'b1;
            slot_c[free_idx] <= add_color;
         end
      end
   end

   // R7: an accepted add lands in the slot advertised the cycle before
   a_r7_add_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (add_en && !full) |=> slot_v[$past(free_idx)]);
   // R8: a remove frees its slot unless an add claims it on the same edge
   a_r8_rm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rm_en && !(add_en && !full && free_idx == rm_idx)) |=> !slot_v[$past(rm_idx)]);
endmodule

// File: rtl/cam_trap_ctrl.sv
module cam_trap_ctrl
   import cam_pkg::*;
#(
   parameter int COLOR_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               need_trap,
   input  logic [COLOR_W-1:0] hit_color,
   input  logic               trap_ack,
   output logic               acc_ready,
   output logic               trap_valid,
   output logic [COLOR_W-1:0] trap_color
);
   hold_state_e        st;
   logic [COLOR_W-1:0] color_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= HOLD_IDLE;
         color_q <= '0;
      end else begin
         case (st)
            HOLD_IDLE: if (acc_valid && need_trap) begin
               st      <= HOLD_TRAP;
               color_q <= hit_color;
            end
            HOLD_TRAP: if (trap_ack) st <= HOLD_IDLE;
            default:   st <= HOLD_IDLE;
         endcase
      end
   end

   assign acc_ready  = (st == HOLD_IDLE) && acc_valid && !need_trap;
   assign trap_valid = (st == HOLD_TRAP);
   assign trap_color = color_q;

   // R6: trap and its color persist until acknowledged
   a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && !trap_ack) |=> (trap_valid && $stable(trap_color)));
   // R6: no access slips through while a trap is pending
   a_r6_block_access: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> !acc_ready);
   // R6: an acknowledge clears the trap on the next cycle
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_ack) |=> !trap_valid);
endmodule

// File: rtl/colored_access_monitor.sv
module colored_access_monitor #(
   parameter int ADDR_W  = 32,
   parameter int COLOR_W = 6,
   parameter int RANGE_N = 8,
   parameter int OWN_N   = 8,
   localparam int RIDX_W = $clog2(RANGE_N),
   localparam int OIDX_W = $clog2(OWN_N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_store,
   input  logic [ADDR_W-1:0]  acc_addr,
   output logic               acc_ready,
   output logic               trap_valid,
   output logic [COLOR_W-1:0] trap_color,
   input  logic               trap_ack,
   input  logic               tbl_wr_en,
   input  logic [RIDX_W-1:0]  tbl_wr_idx,
   input  logic               tbl_wr_valid,
   input  logic [ADDR_W-1:0]  tbl_wr_base,
   input  logic [ADDR_W-1:0]  tbl_wr_limit,
   input  logic [COLOR_W-1:0] tbl_wr_color,
   input  logic               add_en,
   input  logic [COLOR_W-1:0] add_color,
   output logic [OIDX_W-1:0]  add_slot,
   output logic               add_full,
   input  logic               rm_en,
   input  logic [OIDX_W-1:0]  rm_slot
);
   if (RANGE_N < 2 || (1 << RIDX_W) != RANGE_N) begin : g_chk_range
      $error("RANGE_N must be a power of two of at least 2");
   end
   if (OWN_N < 2 || (1 << OIDX_W) != OWN_N) begin : g_chk_own
      $error("OWN_N must be a power of two of at least 2");
   end
   if (COLOR_W < 1 || ADDR_W < 1) begin : g_chk_width
      $error("ADDR_W and COLOR_W must be positive");
   end

   logic               lk_hit;
   logic [COLOR_W-1:0] lk_color;
   logic               owned;
   logic               need_trap;
   logic               kind_unused;

   // R9: the access kind never enters the decision
   assign kind_unused = acc_store;

   cam_range_table #(.ADDR_W(ADDR_W), .COLOR_W(COLOR_W), .N(RANGE_N)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_valid(tbl_wr_valid),
      .wr_base(tbl_wr_base), .wr_limit(tbl_wr_limit), .wr_color(tbl_wr_color),
      .lk_addr(acc_addr), .lk_hit(lk_hit), .lk_color(lk_color)
   );

   cam_owned_set #(.COLOR_W(COLOR_W), .N(OWN_N)) u_own (
      .clk(clk), .rst_n(rst_n),
      .add_en(add_en), .add_color(add_color),
      .rm_en(rm_en), .rm_idx(rm_slot),
      .chk_color(lk_color), .chk_owned(owned),
      .free_idx(add_slot), .full(add_full)
   );

   assign need_trap = lk_hit && !owned;

   cam_trap_ctrl #(.COLOR_W(COLOR_W)) u_trap (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .need_trap(need_trap), .hit_color(lk_color),
      .trap_ack(trap_ack),
      .acc_ready(acc_ready), .trap_valid(trap_valid), .trap_color(trap_color)
   );

   // R3: a trap only opens in response to a presented access
   a_r3_trap_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trap_valid) |-> $past(acc_valid));
   // R2: acceptance implies a presented access
   a_r2_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ready |-> acc_valid);
   // R7: a full set keeps its contents when an add is attempted without a remove
   a_r7_full_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (add_full && !rm_en) |=> add_full);
endmodule

// File: tb/colored_access_monitor_test.sv
module colored_access_monitor_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          acc_valid, acc_store, trap_ack;
   logic [AW-1:0] acc_addr;
   logic          acc_ready, trap_valid;
   logic [CW-1:0] trap_color;
   logic          tbl_wr_en, tbl_wr_valid;
   logic [2:0]    tbl_wr_idx;
   logic [AW-1:0] tbl_wr_base, tbl_wr_limit;
   logic [CW-1:0] tbl_wr_color;
   logic          add_en, add_full, rm_en;
   logic [CW-1:0] add_color;
   logic [2:0]    add_slot, rm_slot;

   int n_chk = 0;
   int n_bad = 0;

   // bench model
   bit          m_v [8];
   int unsigned m_b [8];
   int unsigned m_l [8];
   int          m_c [8];
   bit          o_v [8];
   int          o_c [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   colored_access_monitor uut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_store(acc_store), .acc_addr(acc_addr),
      .acc_ready(acc_ready), .trap_valid(trap_valid), .trap_color(trap_color),
      .trap_ack(trap_ack),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_valid(tbl_wr_valid),
      .tbl_wr_base(tbl_wr_base), .tbl_wr_limit(tbl_wr_limit), .tbl_wr_color(tbl_wr_color),
      .add_en(add_en), .add_color(add_color), .add_slot(add_slot), .add_full(add_full),
      .rm_en(rm_en), .rm_slot(rm_slot)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // color that must trap for addr, or -1 if the access proceeds (R2..R5)
   function automatic int exp_trap(input int unsigned a);
      int c = -1;
      for (int i = 7; i >= 0; i--)
         if (m_v[i] && a >= m_b[i] && a <= m_l[i]) c = m_c[i];
      if (c < 0) return -1;
      for (int i = 0; i < 8; i++)
         if (o_v[i] && o_c[i] == c) return -1;
      return c;
   endfunction

   function automatic int exp_free();
      for (int i = 0; i < 8; i++) if (!o_v[i]) return i;
      return 8;
   endfunction

   task automatic tbl_write(input int idx, input bit v, input int unsigned b,
                            input int unsigned l, input int c);
      @(negedge clk);
      tbl_wr_en = 1; tbl_wr_idx = 3'(idx); tbl_wr_valid = v;
      tbl_wr_base = b; tbl_wr_limit = l; tbl_wr_color = CW'(c);
      @(negedge clk);
      tbl_wr_en = 0;
      m_v[idx] = v; m_b[idx] = b; m_l[idx] = l; m_c[idx] = c;
   endtask

   task automatic do_add(input int c);
      int ef;
      @(negedge clk);
      add_en = 1; add_color = CW'(c);
      #1;
      ef = exp_free();
      chk(add_full == (ef == 8), "R7 full flag", int'(add_full), int'(ef == 8));
      if (ef != 8) chk(int'(add_slot) == ef, "R7 free slot", int'(add_slot), ef);
      @(negedge clk);
      add_en = 0;
      if (ef != 8) begin o_v[ef] = 1; o_c[ef] = c; end
   endtask

   task automatic do_rm(input int s);
      @(negedge clk);
      rm_en = 1; rm_slot = 3'(s);
      @(negedge clk);
      rm_en = 0;
      o_v[s] = 0;
   endtask

   // mode 0: ack without fixing; 1: add the color during the trap; 2: hold 3 cycles first
   task automatic do_access(input int unsigned a, input bit st, input int mode, input string req);
      int ec, ef;
      @(negedge clk);
      acc_valid = 1; acc_store = st; acc_addr = a;
      #1;
      ec = exp_trap(a);
      chk(acc_ready == (ec < 0), req, int'(acc_ready), int'(ec < 0));
      @(negedge clk);
      #1;
      if (ec < 0) begin
         chk(trap_valid == 0, {req, " no trap"}, int'(trap_valid), 0);
         acc_valid = 0;
         return;
      end
      chk(trap_valid == 1 && int'(trap_color) == ec, {req, " trap color"},
          trap_valid ? int'(trap_color) : -1, ec);
      if (mode == 2) begin
         for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk(trap_valid == 1 && !acc_ready && int'(trap_color) == ec,
                "R6 trap held", trap_valid ? int'(trap_color) : -1, ec);
         end
      end
      trap_ack = 1;
      ef = 8;
      if (mode == 1) begin
         add_en = 1; add_color = CW'(ec);
         #1;
         ef = exp_free();
         chk(add_full == (ef == 8), "R7 full flag in trap", int'(add_full), int'(ef == 8));
         if (ef != 8) chk(int'(add_slot) == ef, "R7 slot in trap", int'(add_slot), ef);
      end
      @(negedge clk);
      trap_ack = 0; add_en = 0;
      if (ef != 8) begin o_v[ef] = 1; o_c[ef] = ec; end
      #1;
      chk(trap_valid == 0, "R6 ack clears", int'(trap_valid), 0);
      chk(acc_ready == (exp_trap(a) < 0), "R6 recheck", int'(acc_ready), int'(exp_trap(a) < 0));
      acc_valid = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      for (int i = 0; i < 8; i++) begin m_v[i] = 0; o_v[i] = 0; end
      rst_n = 0; acc_valid = 0; acc_store = 0; acc_addr = '0; trap_ack = 0;
      tbl_wr_en = 0; tbl_wr_idx = '0; tbl_wr_valid = 0; tbl_wr_base = '0;
      tbl_wr_limit = '0; tbl_wr_color = '0; add_en = 0; add_color = '0;
      rm_en = 0; rm_slot = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk(trap_valid == 0, "R1 no trap", int'(trap_valid), 0);
      chk(add_slot == 0 && add_full == 0, "R1 empty set", int'(add_slot), 0);
      do_access(32'h0000_0150, 0, 0, "R1 empty table");

      // directed: overlapping ranges
      tbl_write(0, 1, 32'h100, 32'h1FF, 5);
      tbl_write(1, 1, 32'h180, 32'h2FF, 9);
      do_access(32'h0FF, 0, 0, "R2 below base");
      do_access(32'h300, 0, 0, "R2 above limit");
      do_access(32'h100, 0, 0, "R3 at base");
      do_access(32'h1FF, 0, 0, "R3 at limit");
      do_access(32'h1C0, 0, 0, "R4 lowest entry wins");
      do_access(32'h250, 0, 0, "R3 second entry");
      do_access(32'h100, 1, 0, "R9 store trap");
      do_access(32'h0FF, 1, 0, "R9 store uncolored");
      do_access(32'h120, 0, 2, "R6 hold");
      do_access(32'h120, 0, 1, "R6 add in trap");
      do_access(32'h1C0, 1, 0, "R5 owned low entry");
      do_access(32'h250, 0, 0, "R4 higher entry unowned");

      // fill the set: slot 0 holds 5 already
      for (int c = 20; c < 27; c++) do_add(c);
      do_add(40);
      chk(add_full == 1, "R7 full after 8", int'(add_full), 1);
      do_rm(3);
      do_add(9);
      do_access(32'h250, 0, 0, "R5 owned in slot 3");
      do_rm(0);
      do_access(32'h100, 0, 0, "R8 removed color traps");
      do_add(5);
      do_access(32'h100, 1, 0, "R7 reused slot");
      tbl_write(0, 0, 32'h100, 32'h1FF, 5);
      do_rm(3);
      do_access(32'h120, 0, 0, "R10 invalid entry");
      do_access(32'h1C0, 0, 0, "R10 falls to entry 1");

      // random phase
      for (int it = 0; it < 400; it++) begin
         int op = $urandom % 10;
         if (op < 2) begin
            int unsigned b = $urandom % 256;
            tbl_write($urandom % 8, ($urandom % 4) != 0, b, b + ($urandom % 64),
                      $urandom % 8);
         end else if (op == 2) begin
            do_add($urandom % 8);
         end else if (op == 3) begin
            do_rm($urandom % 8);
         end else begin
            do_access($urandom % 320, 1'($urandom), $urandom % 3, "R3 R5 random");
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule